// File: doc/BRIEF.md
# Interrupt Enable and Routing Unit

This unit takes a bank of level-sensitive interrupt request lines and decides, one source at a time, whether each may interrupt the processor and through which of two outputs. Each source has an enable bit and a class bit. A source whose class bit is 1 feeds the fast interrupt output (FIQ). A source whose class bit is 0 feeds the normal interrupt output (IRQ). A source only reaches either output when it is enabled and its request line is high.

Software reaches the unit through a plain register port with an address, write data, a write strobe, a read strobe and read data. Enable bits are never written directly. One location turns on every enable bit for which a 1 is written, and a second location turns off every enable bit for which a 1 is written. A single store therefore changes chosen sources without touching the others, and software never needs to read the enable register first. Read-only views show the masked requests of each class and the raw request lines. The two combined outputs are registered, so they follow the request lines one clock later.

Top module: `irq_route_unit`

## Requirements
- R1: A write to offset 0x010 sets each enable bit for which the written bit is 1 and leaves the other enable bits unchanged. A read of 0x010 returns the enable bits.
- R2: A write to offset 0x014 clears each enable bit for which the written bit is 1 and leaves the other enable bits unchanged. A read of 0x014 returns 0.
- R3: Offset 0x00C holds the class register, which reads back the last value written. Bit value 1 puts that source in the FIQ class and 0 puts it in the IRQ class.
- R4: A read of offset 0x000 returns, for each bit, request AND enable AND NOT class.
- R5: A read of offset 0x004 returns, for each bit, request AND enable AND class.
- R6: A read of offset 0x008 returns the raw request lines.
- R7: `irq_o` is the OR of the IRQ-class masked bits and `fiq_o` is the OR of the FIQ-class masked bits. Both are registered, so each takes the value of the previous cycle.
- R8: After reset the enable and class registers are 0, both status views read 0, and `irq_o` and `fiq_o` are 0.
- R9: A read at any offset other than 0x000, 0x004, 0x008, 0x00C, 0x010 and 0x014 returns 0. A write to such an offset, or to 0x000, 0x004 or 0x008, changes no register.
- R10: `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Level-sensitive request lines, one bit per source |
| addr | input | 8 | Byte offset of the register being accessed |
| wr_en | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational from `addr` while `rd_en` is high |
| fiq_o | output | 1 | Combined fast interrupt, registered |
| irq_o | output | 1 | Combined normal interrupt, registered |

## Verification
On every cycle the assertions check several properties. A set write leaves every written-1 bit enabled, and a clear write leaves every written-1 bit disabled. The enable bits do not move without a write strobe. The two classes never flag the same source. Each combined output equals the previous cycle's OR of its class. Unmapped reads return 0. Other behaviour can only be shown by the bench's scenarios, which compare every read view and both outputs against a reference model: that written 0s really leave bits alone, that writes to read-only or unmapped offsets change nothing, and that the mapping of offsets to views is correct.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [31:0] OFS_IRQ_VIEW = 32'h000;
  localparam logic [31:0] OFS_FIQ_VIEW = 32'h004;
  localparam logic [31:0] OFS_RAW_VIEW = 32'h008;
  localparam logic [31:0] OFS_CLASS    = 32'h00C;
  localparam logic [31:0] OFS_EN_SET   = 32'h010;
  localparam logic [31:0] OFS_EN_CLR   = 32'h014;

  typedef enum logic [2:0] {
    LOC_NONE,
    LOC_IRQ_VIEW,
    LOC_FIQ_VIEW,
    LOC_RAW_VIEW,
    LOC_CLASS,
    LOC_EN_SET,
    LOC_EN_CLR
  } reg_loc_e;

  function automatic reg_loc_e decode_offset(input logic [31:0] ofs);
    case (ofs)
      OFS_IRQ_VIEW: return LOC_IRQ_VIEW;
      OFS_FIQ_VIEW: return LOC_FIQ_VIEW;
      OFS_RAW_VIEW: return LOC_RAW_VIEW;
      OFS_CLASS:    return LOC_CLASS;
      OFS_EN_SET:   return LOC_EN_SET;
      OFS_EN_CLR:   return LOC_EN_CLR;
      default:      return LOC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output reg_loc_e          loc,
  output logic              set_hit,
  output logic              clr_hit,
  output logic              cls_hit
);
  always_comb begin
    loc     = decode_offset(32'(addr));
    set_hit = wr_en && (loc == LOC_EN_SET);
    clr_hit = wr_en && (loc == LOC_EN_CLR);
    cls_hit = wr_en && (loc == LOC_CLASS);
  end

  always_comb begin
    a_r9_one_write_target: assert ({set_hit, clr_hit, cls_hit} == 3'b000 ||
                                   $onehot({set_hit, clr_hit, cls_hit}));
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_hit,
  input  logic             clr_hit,
  input  logic             cls_hit,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] cls_q
);
  // Clear has priority over set for any bit that both target.
  function automatic logic [N_SRC-1:0] next_enable(
    input logic [N_SRC-1:0] cur,
    input logic [N_SRC-1:0] set_mask,
    input logic [N_SRC-1:0] clr_mask
  );
    return (cur | set_mask) & ~clr_mask;
  endfunction

  logic [N_SRC-1:0] set_mask, clr_mask, en_d;

  assign set_mask = set_hit ? wdata : '0;
  assign clr_mask = clr_hit ? wdata : '0;
  assign en_d     = next_enable(en_q, set_mask, clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cls_q <= '0;
    end else begin
      en_q <= en_d;
      if (cls_hit) cls_q <= wdata;
    end
  end

  a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((en_q & $past(wdata)) == $past(wdata)));
  a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((en_q & $past(wdata)) == '0));
  a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(en_q));
  a_r3_class_written: assert property (@(posedge clk) disable iff (!rst_n)
    cls_hit |=> (cls_q == $past(wdata)));
endmodule

// File: rtl/irq_route_status.sv
module irq_route_status #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] cls,
  output logic [N_SRC-1:0] irq_vec,
  output logic [N_SRC-1:0] fiq_vec,
  output logic             irq_o,
  output logic             fiq_o
);
  function automatic logic [N_SRC-1:0] masked(
    input logic [N_SRC-1:0] r,
    input logic [N_SRC-1:0] e,
    input logic [N_SRC-1:0] c,
    input logic             want_fast
  );
    return r & e & (want_fast ? c : ~c);
  endfunction

  logic irq_any, fiq_any;

  assign irq_vec = masked(req, en, cls, 1'b0);
  assign fiq_vec = masked(req, en, cls, 1'b1);
  assign irq_any = |irq_vec;
  assign fiq_any = |fiq_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_any;
      fiq_o <= fiq_any;
    end
  end

  a_r4_classes_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec & fiq_vec) == '0);
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(req & en & ~cls))));
  a_r7_fiq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_o == $past(|(req & en & cls))));
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
  import irq_route_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [N_SRC-1:0]  wr_data,
  input  logic              rd_en,
  output logic [N_SRC-1:0]  rd_data,
  output logic              fiq_o,
  output logic              irq_o
);
  reg_loc_e         loc;
  logic             set_hit, clr_hit, cls_hit;
  logic [N_SRC-1:0] en_q, cls_q, irq_vec, fiq_vec;
  logic [N_SRC-1:0] view;

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .loc(loc),
    .set_hit(set_hit), .clr_hit(clr_hit), .cls_hit(cls_hit)
  );

  irq_mask_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_hit(set_hit), .clr_hit(clr_hit),
    .cls_hit(cls_hit), .wdata(wr_data), .en_q(en_q), .cls_q(cls_q)
  );

  irq_route_status #(.N_SRC(N_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .req(req_i), .en(en_q), .cls(cls_q),
    .irq_vec(irq_vec), .fiq_vec(fiq_vec), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always_comb begin
    case (loc)
      LOC_IRQ_VIEW: view = irq_vec;
      LOC_FIQ_VIEW: view = fiq_vec;
      LOC_RAW_VIEW: view = req_i;
      LOC_CLASS:    view = cls_q;
      LOC_EN_SET:   view = en_q;
      default:      view = '0;
    endcase
  end

  assign rd_data = rd_en ? view : '0;

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (loc == LOC_NONE || loc == LOC_EN_CLR)) |-> (rd_data == '0));
  a_r10_idle_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: tb/sim_irq_route_unit.sv
module sim_irq_route_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_i = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        fiq_o, irq_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_en = '0, m_cls = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .fiq_o(fiq_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_view(input logic [7:0] a);
    case (a)
      8'h00: return req_i & m_en & ~m_cls;
      8'h04: return m_en & m_cls & req_i;
      8'h08: return req_i;
      8'h0C: return m_cls;
      8'h10: return m_en;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      8'h10: m_en = m_en | d;
      8'h14: m_en = m_en & ~d;
      8'h0C: m_cls = d;
      default: ;
    endcase
  endtask

  task automatic rd_check(input logic [7:0] a, input string tag);
    addr = a; rd_en = 1'b1;
    #1;
    check(tag, rd_data, exp_view(a));
    rd_en = 1'b0;
  endtask

  task automatic check_all(input string tag);
    // Outputs are registered: allow one clock edge after the last change.
    @(negedge clk);
    rd_check(8'h00, {tag, " R4"});
    rd_check(8'h04, {tag, " R5"});
    rd_check(8'h08, {tag, " R6"});
    rd_check(8'h0C, {tag, " R3"});
    rd_check(8'h10, {tag, " R1"});
    rd_check(8'h14, {tag, " R2"});
    check({tag, " R7 irq"}, 32'(irq_o), 32'(|(req_i & m_en & ~m_cls)));
    check({tag, " R7 fiq"}, 32'(fiq_o), 32'(|(req_i & m_en & m_cls)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req_i = 32'hFFFF_FFFF;
    // R8: reset state
    check_all("R8 reset");
    check("R8 irq_o", 32'(irq_o), 32'h0);

    // R1: set only written ones
    wr(8'h10, 32'h0000_00F0); check_all("R1 set");
    wr(8'h10, 32'h0000_0003); check_all("R1 set keeps");
    // R2: clear only written ones
    wr(8'h14, 32'h0000_0011); check_all("R2 clear");
    // R3: class routing, FIQ vs IRQ
    wr(8'h0C, 32'h0000_00A0); check_all("R3 class");
    req_i = 32'h0000_0020;    check_all("R7 fiq only");
    req_i = 32'h0000_0040;    check_all("R7 irq only");
    // R9: writes to read-only and unmapped offsets do nothing
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h0D, 32'hFFFF_FFFF); check_all("R9 ignored writes");
    rd_check(8'h18, "R9 unmapped read"); rd_check(8'h7C, "R9 unmapped read hi");
    // R10: idle port reads zero
    addr = 8'h10; rd_en = 1'b0; #1; check("R10 idle", rd_data, 32'h0);
    // boundary bits
    wr(8'h10, 32'h8000_0001); wr(8'h0C, 32'h8000_0000);
    req_i = 32'h8000_0001;    check_all("R5 msb fiq");
    wr(8'h14, 32'hFFFF_FFFF); check_all("R2 clear all");

    for (int i = 0; i < 400; i++) begin
      case ($urandom % 5)
        0: wr(8'h10, $urandom);
        1: wr(8'h14, $urandom);
        2: wr(8'h0C, $urandom);
        3: wr(8'(($urandom % 64) * 4), $urandom);
        default: req_i = $urandom & $urandom;
      endcase
      check_all("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule